// File: doc/BRIEF.md
# Dual-Trigger Key Interrupt Generator

This block produces the interrupt pin for a key-scan controller. Two independent triggers can raise it. A timer trigger counts debounce-period ticks after the most recent key event and fires once a programmed number of periods has passed. A queue trigger watches the number of events held in the key event queue and fires when that number reaches a programmed threshold. The interrupt is raised by whichever trigger fires first. It stays raised until the clear condition that the clear-mode input selects.

The pin is open-drain and active low. The block presents it as a pull-down enable: `irq_oe_o` high pulls the pin low, and `irq_oe_o` low releases it. If the whole 8-bit interrupt setting is zero, both triggers are bypassed and the pin becomes a plain output that follows a port-register bit. Register decoding sits outside this block. It delivers the setting, the clear-mode bit, the port bit, the queue fill level and a read strobe.

Top module: `key_irq_gen`

## Requirements
- R1: During reset `irq_oe_o` is 0 whenever the setting is non-zero. Asserting `rst_ni` clears the pending interrupt at once, without waiting for a clock edge.
- R2: With time code T = `irq_cfg_i[4:0]` in the range 1..31, the interrupt is raised on the clock edge that samples the T-th `tick_i` after the latest `key_evt_i`. `irq_oe_o` is 1 from that edge on.
- R3: A new `key_evt_i` restarts the timer from T. A `tick_i` in the same cycle as `key_evt_i` is not counted.
- R4: Time code 0 disables the timer trigger. Key events and ticks then raise nothing.
- R5: With queue code n = `irq_cfg_i[7:5]` in the range 1..7, the threshold is 2·n events. The interrupt is raised on the edge where `fifo_cnt_i` goes from below the threshold to at or above it. A level that stays at or above the threshold does not raise it again.
- R6: Queue code 0 disables the queue trigger, whatever the fill level.
- R7: With both triggers enabled, the first one to fire raises the interrupt. A second firing while it is pending leaves it raised.
- R8: With `clr_on_read_i` = 1, a cycle with `fifo_rd_i` = 1 clears the interrupt at the next edge.
- R9: With `clr_on_read_i` = 0, reads do not clear the interrupt. It clears at the edge that samples `fifo_cnt_i` = 0.
- R10: If a trigger fires in the same cycle as a clear condition, the interrupt is raised.
- R11: While `irq_cfg_i` = 8'h00, `irq_oe_o` = ~`gpo_val_i` in the same cycle (0 releases the pin, 1 pulls it low), and any pending interrupt is hidden.
- R12: After the timer trigger has fired, further ticks raise nothing until the next key event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_cfg_i | input | 8 | Interrupt setting: [4:0] time code, [7:5] queue code |
| clr_on_read_i | input | 1 | Clear mode: 1 clears on read, 0 clears when queue empties |
| gpo_val_i | input | 1 | Port bit that drives the pin when the setting is zero |
| tick_i | input | 1 | One-cycle pulse per debounce period |
| key_evt_i | input | 1 | One-cycle pulse for a new key event |
| fifo_cnt_i | input | 5 | Number of events currently stored in the queue |
| fifo_rd_i | input | 1 | One-cycle pulse for a queue read |
| irq_oe_o | output | 1 | Open-drain pull-down enable: 1 drives the pin low |

## Verification
Trigger and clear results come from one flag register, so `irq_oe_o` changes on the first clock edge that samples the causing input. The bench drives each vector on a falling edge and compares on the next falling edge, which falls after exactly that one rising edge. The plain-output mode is combinational. It is checked in the same half-cycle window, so it shows no delay. The reset clear is asynchronous and is checked a nanosecond after `rst_ni` falls, away from any clock edge.

// File: rtl/key_irq_pkg.sv
package key_irq_pkg;
  localparam int unsigned TCODE_W = 5;
  localparam int unsigned QCODE_W = 3;
  localparam int unsigned CFG_W   = TCODE_W + QCODE_W;

  typedef struct packed {
    logic [QCODE_W-1:0] qcode;
    logic [TCODE_W-1:0] tcode;
  } irq_cfg_t;
endpackage

// File: rtl/key_irq_timer.sv
module key_irq_timer #(
  parameter int unsigned TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tcode_i,
  input  logic          evt_i,
  input  logic          tick_i,
  output logic          fire_o
);
  logic [TW-1:0] left_q;
  logic          armed_q;
  logic          last;

  assign last   = (left_q == TW'(1));
  assign fire_o = tick_i & armed_q & ~evt_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (evt_i) begin
      left_q  <= tcode_i;
      armed_q <= |tcode_i;
    end else if (tick_i && armed_q) begin
      left_q <= left_q - TW'(1);
      if (last) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/key_irq_qtrig.sv
module key_irq_qtrig #(
  parameter int unsigned QW = 3,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [QW-1:0] qcode_i,
  input  logic [CW-1:0] cnt_i,
  output logic          fire_o
);
  logic [CW-1:0] thr;
  logic          reached;
  logic          reached_q;

  assign thr     = CW'({qcode_i, 1'b0});
  assign reached = (|qcode_i) && (cnt_i >= thr);
  assign fire_o  = reached & ~reached_q;  // edge only: a held level fires once

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reached_q <= 1'b0;
    else         reached_q <= reached;
  end
endmodule

// File: rtl/key_irq_out.sv
module key_irq_out #(
  parameter int unsigned NTRIG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTRIG-1:0] fire_i,
  input  logic             clr_on_read_i,
  input  logic             rd_i,
  input  logic             empty_i,
  input  logic             gpo_mode_i,
  input  logic             gpo_val_i,
  output logic             flag_o,
  output logic             oe_o
);
  logic set, clr, flag_q;

  assign set = |fire_i;
  assign clr = clr_on_read_i ? rd_i : empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;  // set beats clear
    else if (clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign oe_o   = gpo_mode_i ? ~gpo_val_i : flag_q;
endmodule

// File: rtl/key_irq_gen.sv
module key_irq_gen
  import key_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] irq_cfg_i,
  input  logic             clr_on_read_i,
  input  logic             gpo_val_i,
  input  logic             tick_i,
  input  logic             key_evt_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             fifo_rd_i,
  output logic             irq_oe_o
);
  localparam int unsigned NTRIG = 2;

  irq_cfg_t         cfg;
  logic             time_fire, queue_fire, flag;
  logic [NTRIG-1:0] fires;

  assign cfg   = irq_cfg_t'(irq_cfg_i);
  assign fires = {queue_fire, time_fire};

  key_irq_timer #(.TW(TCODE_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tcode_i(cfg.tcode),
    .evt_i  (key_evt_i),
    .tick_i (tick_i),
    .fire_o (time_fire)
  );

  key_irq_qtrig #(.QW(QCODE_W), .CW(CNT_W)) u_qtrig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qcode_i(cfg.qcode),
    .cnt_i  (fifo_cnt_i),
    .fire_o (queue_fire)
  );

  key_irq_out #(.NTRIG(NTRIG)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fires),
    .clr_on_read_i(clr_on_read_i),
    .rd_i         (fifo_rd_i),
    .empty_i      (fifo_cnt_i == '0),
    .gpo_mode_i   (irq_cfg_i == '0),
    .gpo_val_i    (gpo_val_i),
    .flag_o       (flag),
    .oe_o         (irq_oe_o)
  );
endmodule

// File: rtl/key_irq_chk.sv
module key_irq_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       cfg_i,
  input logic             clr_on_read_i,
  input logic             gpo_val_i,
  input logic             fifo_rd_i,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             time_fire_i,
  input logic             queue_fire_i,
  input logic             flag_i,
  input logic             oe_i
);
  // R10
  fire_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_fire_i || queue_fire_i) |=> flag_i);

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_on_read_i && fifo_rd_i && !time_fire_i && !queue_fire_i) |=> !flag_i);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_on_read_i && fifo_cnt_i != '0 && flag_i) |=> flag_i);

  // R4
  time_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[4:0] == 5'd0) |-> !time_fire_i);

  // R6
  queue_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[7:5] == 3'd0) |-> !queue_fire_i);

  // R11
  gpo_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 8'h00) |-> (oe_i == !gpo_val_i));

  // R7
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(time_fire_i || queue_fire_i));
endmodule

bind key_irq_gen key_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_i        (irq_cfg_i),
  .clr_on_read_i(clr_on_read_i),
  .gpo_val_i    (gpo_val_i),
  .fifo_rd_i    (fifo_rd_i),
  .fifo_cnt_i   (fifo_cnt_i),
  .time_fire_i  (time_fire),
  .queue_fire_i (queue_fire),
  .flag_i       (flag),
  .oe_i         (irq_oe_o)
);

// File: tb/key_irq_gen_tb.sv
module key_irq_gen_tb;
  localparam int NV = 51;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_cfg_i = 8'h03;
  logic       clr_on_read_i = 1'b1;
  logic       gpo_val_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       key_evt_i = 1'b0;
  logic [4:0] fifo_cnt_i = '0;
  logic       fifo_rd_i = 1'b0;
  logic       irq_oe_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  key_irq_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_cfg_i(irq_cfg_i),
    .clr_on_read_i(clr_on_read_i), .gpo_val_i(gpo_val_i), .tick_i(tick_i),
    .key_evt_i(key_evt_i), .fifo_cnt_i(fifo_cnt_i), .fifo_rd_i(fifo_rd_i),
    .irq_oe_o(irq_oe_o)
  );

  // {cfg, clr/gpo/tick/evt, cnt, rd/exp}
  localparam logic [18:0] VEC [0:NV-1] = '{
    {8'h03, 4'b1101, 5'd1,  2'b00},  // 0  R2 arm T=3
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 1  R2
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 2  R2
    {8'h03, 4'b1110, 5'd1,  2'b01},  // 3  R2 third tick
    {8'h03, 4'b1100, 5'd0,  2'b10},  // 4  R8 read clears
    {8'h03, 4'b1110, 5'd0,  2'b00},  // 5  R12 disarmed
    {8'h03, 4'b1101, 5'd1,  2'b00},  // 6  R3
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 7  R3
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 8  R3
    {8'h03, 4'b1111, 5'd1,  2'b00},  // 9  R3 restart, tick ignored
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 10 R3
    {8'h03, 4'b1110, 5'd1,  2'b00},  // 11 R3
    {8'h03, 4'b1110, 5'd1,  2'b01},  // 12 R3
    {8'h03, 4'b1100, 5'd0,  2'b10},  // 13 R8
    {8'h20, 4'b1101, 5'd1,  2'b00},  // 14 R4
    {8'h20, 4'b1110, 5'd1,  2'b00},  // 15 R4
    {8'h20, 4'b1110, 5'd1,  2'b00},  // 16 R4
    {8'h20, 4'b1100, 5'd2,  2'b01},  // 17 R5 thr 2
    {8'h20, 4'b1100, 5'd1,  2'b10},  // 18 R8
    {8'h20, 4'b1100, 5'd2,  2'b01},  // 19 R5
    {8'h20, 4'b1100, 5'd2,  2'b10},  // 20 R5 held level no refire
    {8'h40, 4'b0100, 5'd3,  2'b00},  // 21 R5 thr 4
    {8'h40, 4'b0100, 5'd4,  2'b01},  // 22 R5
    {8'h40, 4'b0100, 5'd3,  2'b11},  // 23 R9 read ignored
    {8'h40, 4'b0100, 5'd1,  2'b01},  // 24 R9
    {8'h40, 4'b0100, 5'd0,  2'b00},  // 25 R9 empty clears
    {8'hE2, 4'b1101, 5'd1,  2'b00},  // 26 R7
    {8'hE2, 4'b1110, 5'd1,  2'b00},  // 27 R7
    {8'hE2, 4'b1110, 5'd1,  2'b01},  // 28 R7 timer first
    {8'hE2, 4'b1100, 5'd14, 2'b01},  // 29 R7 queue later
    {8'hE2, 4'b1100, 5'd13, 2'b10},  // 30 R8
    {8'hE2, 4'b1101, 5'd13, 2'b00},  // 31 R7
    {8'hE2, 4'b1100, 5'd14, 2'b01},  // 32 R7 queue first
    {8'hE2, 4'b1100, 5'd13, 2'b10},  // 33 R8
    {8'hE2, 4'b1110, 5'd13, 2'b00},  // 34 R7
    {8'hE2, 4'b1110, 5'd13, 2'b01},  // 35 R7 timer later
    {8'hE2, 4'b1100, 5'd13, 2'b10},  // 36 R8
    {8'hE2, 4'b1101, 5'd13, 2'b00},  // 37 R10
    {8'hE2, 4'b1110, 5'd13, 2'b00},  // 38 R10
    {8'hE2, 4'b1110, 5'd13, 2'b11},  // 39 R10 fire+read
    {8'hE2, 4'b1100, 5'd0,  2'b10},  // 40 R8
    {8'h00, 4'b1100, 5'd0,  2'b00},  // 41 R11
    {8'h00, 4'b1000, 5'd0,  2'b01},  // 42 R11
    {8'h00, 4'b1011, 5'd0,  2'b01},  // 43 R11
    {8'h00, 4'b1100, 5'd14, 2'b00},  // 44 R11
    {8'h20, 4'b0100, 5'd2,  2'b01},  // 45 R11 set flag
    {8'h00, 4'b0100, 5'd2,  2'b00},  // 46 R11 flag hidden
    {8'h20, 4'b0100, 5'd2,  2'b01},  // 47 R11
    {8'h20, 4'b0100, 5'd0,  2'b00},  // 48 R9
    {8'h01, 4'b1100, 5'd15, 2'b00},  // 49 R6
    {8'h01, 4'b1110, 5'd15, 2'b00}   // 50 R6
  };

  localparam int VREQ [0:NV-1] = '{
    2,2,2,2,8,12,3,3,3,3,3,3,3,8,4,4,4,5,8,5,5,5,5,9,9,9,
    7,7,7,7,8,7,7,8,7,7,8,10,10,10,8,11,11,11,11,11,11,11,9,6,6
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_oe_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", irq_oe_o, 1'b0);  // R1 reset state
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {irq_cfg_i, clr_on_read_i, gpo_val_i, tick_i, key_evt_i, fifo_cnt_i, fifo_rd_i} = VEC[i][18:1];
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", VREQ[i], i), irq_oe_o, VEC[i][0]);
    end

    // R2 longest window: T=31
    irq_cfg_i = 8'h1F; clr_on_read_i = 1'b1; gpo_val_i = 1'b1;
    fifo_cnt_i = 5'd1; fifo_rd_i = 1'b0; tick_i = 1'b0; key_evt_i = 1'b1;
    @(negedge clk_i);
    key_evt_i = 1'b0; tick_i = 1'b1;
    repeat (30) @(negedge clk_i);
    check("R2 T=31 after 30 ticks", irq_oe_o, 1'b0);
    @(negedge clk_i);
    check("R2 T=31 after 31 ticks", irq_oe_o, 1'b1);
    tick_i = 1'b0;

    // R1 asynchronous clear
    #5 rst_ni = 1'b0;
    #1 check("R1 async clear", irq_oe_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1; fifo_cnt_i = 5'd0;
    @(negedge clk_i);
    check("R1 after release", irq_oe_o, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule